// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Controller

This block holds the replacement state for a 4-way set-associative cache and names the way to evict on a miss. Each set carries a three-bit binary decision tree instead of a full recency order. True LRU would need six bits per set. A root flag picks between the lower pair (ways 0/1) and the upper pair (ways 2/3). Two leaf flags each pick one way inside their pair. Every use of a way turns the flags on its path so that they point away from it.

The cache pipeline presents a set index together with that set's per-way valid bits. It reads the suggested victim combinationally in the same cycle. An empty way always wins over the tree. When several ways are empty, the lowest-numbered one is taken. When the lookup resolves, the pipeline raises `acc_valid` for one cycle per access:
- On a hit, it gives the hit way.
- On a miss, it gives the way that was filled.

The controller updates that set's tree on the clock edge. Control pins are plain and there is no back-pressure: an access is accepted on every cycle it is presented, including back-to-back accesses to the same set. Tag lookup, data storage and writeback belong to the surrounding cache.

Top module: `plru_repl_ctrl`

## Requirements
- R1: After reset, every set's tree state is zero (root, lower leaf and upper leaf all 0), so with all ways valid the victim of every set is way 0.
- R2: With all four ways valid, the victim is chosen as follows:
  - root=0 and lower leaf=0 gives way 0;
  - root=0 and lower leaf=1 gives way 1;
  - root=1 and upper leaf=0 gives way 2;
  - root=1 and upper leaf=1 gives way 3.
- R3: Referencing way 0 sets root=1 and lower leaf=1. Referencing way 1 sets root=1 and lower leaf=0. In both cases the upper leaf keeps its value.
- R4: Referencing way 2 sets root=0 and upper leaf=1. Referencing way 3 sets root=0 and upper leaf=0. In both cases the lower leaf keeps its value.
- R5: When any bit of `way_valid` (bit i for way i) is 0, the victim is the lowest-numbered way whose bit is 0, whatever the tree holds.
- R6: On an access with `acc_hit`=1 the referenced way is `hit_way`, and `fill_way` is ignored. With `acc_hit`=0 the referenced way is `fill_way`, and `hit_way` is ignored.
- R7: The update is written on the rising edge at which `acc_valid` is 1. It is visible to a read or access of the same set in the next cycle, including back-to-back accesses. While `acc_valid` is 0, no state changes.
- R8: An access changes only the state of the addressed set; all other sets keep their state.
- R9: `victim_way` is combinational from `acc_set` and `way_valid` and the stored state, valid in the same cycle without needing `acc_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One access to commit this cycle |
| acc_set | input | SET_W | Set index for victim read and update |
| acc_hit | input | 1 | 1 = hit, 0 = miss fill |
| hit_way | input | 2 | Way that hit |
| way_valid | input | 4 | Valid bit of each way in the addressed set |
| fill_way | input | 2 | Way filled after a miss |
| victim_way | output | 2 | Way proposed for replacement |

## Verification
The hardest situation to reach from the ports is a leaf flag keeping its value while the other half of the tree is updated. The flags can only be seen through the victim, and that shows one leaf at a time. The stimulus therefore first loads a leaf with a reference to the opposite pair. It then references a way in the other pair, then swings the root back, so that the kept leaf decides the victim. Back-to-back accesses to one set are driven on consecutive cycles to show that the second update builds on the first.

// File: rtl/plru_pkg.sv
package plru_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef logic [WAY_W-1:0] way_t;

  // root chooses pair, lo_leaf inside ways 0/1, hi_leaf inside ways 2/3
  typedef struct packed {
    logic hi_leaf;
    logic lo_leaf;
    logic root;
  } tree_t;

  localparam tree_t TREE_RESET = '{hi_leaf: 1'b0, lo_leaf: 1'b0, root: 1'b0};
endpackage

// File: rtl/plru_victim_pick.sv
module plru_victim_pick
  import plru_pkg::*;
(
  input  tree_t            tree,
  input  logic [WAYS-1:0]  way_valid,
  output way_t             victim
);
  way_t tree_way;
  way_t empty_way;
  logic any_empty;

  // walk the tree: root picks the pair, the pair's leaf picks the way
  always_comb begin
    if (!tree.root) tree_way = tree.lo_leaf ? way_t'(1) : way_t'(0);
    else            tree_way = tree.hi_leaf ? way_t'(3) : way_t'(2);
  end

  // lowest-numbered empty way; scan downward so the lowest wins
  always_comb begin
    empty_way = '0;
    any_empty = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!way_valid[i]) begin
        empty_way = way_t'(i);
        any_empty = 1'b1;
      end
    end
  end

  assign victim = any_empty ? empty_way : tree_way;

  always_comb begin
    if (!(&way_valid)) begin
      assert_victim_empty_R5: assert (!way_valid[victim])
        else $error("victim way %0d is valid while an empty way exists", victim);
    end
  end
endmodule

// File: rtl/plru_tree_update.sv
module plru_tree_update
  import plru_pkg::*;
(
  input  tree_t cur,
  input  way_t  ref_way,
  output tree_t nxt
);
  always_comb begin
    nxt = cur;
    unique case (ref_way)
      2'd0: begin nxt.root = 1'b1; nxt.lo_leaf = 1'b1; end
      2'd1: begin nxt.root = 1'b1; nxt.lo_leaf = 1'b0; end
      2'd2: begin nxt.root = 1'b0; nxt.hi_leaf = 1'b1; end
      default: begin nxt.root = 1'b0; nxt.hi_leaf = 1'b0; end
    endcase
  end

  always_comb begin
    if (!ref_way[1]) begin
      assert_keep_hi_R3: assert (nxt.hi_leaf == cur.hi_leaf)
        else $error("upper leaf changed on lower-pair reference");
    end else begin
      assert_keep_lo_R4: assert (nxt.lo_leaf == cur.lo_leaf)
        else $error("lower leaf changed on upper-pair reference");
    end
  end
endmodule

// File: rtl/plru_repl_ctrl.sv
module plru_repl_ctrl
  import plru_pkg::*;
#(
  parameter  int NUM_SETS = 64,
  localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic             acc_hit,
  input  logic [1:0]       hit_way,
  input  logic [3:0]       way_valid,
  input  logic [1:0]       fill_way,
  output logic [1:0]       victim_way
);
  tree_t state_q [NUM_SETS];
  tree_t cur_tree;
  tree_t nxt_tree;
  way_t  ref_way;

  assign cur_tree = state_q[acc_set];
  assign ref_way  = acc_hit ? hit_way : fill_way;

  plru_victim_pick u_pick (
    .tree      (cur_tree),
    .way_valid (way_valid),
    .victim    (victim_way)
  );

  plru_tree_update u_upd (
    .cur     (cur_tree),
    .ref_way (ref_way),
    .nxt     (nxt_tree)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) state_q[s] <= TREE_RESET;
    end else if (acc_valid) begin
      state_q[acc_set] <= nxt_tree;
    end
  end

  // a just-referenced way is never the next tree victim of its set
  assert_moved_away_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_valid) && $past(rst_n) && (acc_set == $past(acc_set)) && (&way_valid))
      |-> (victim_way != $past(ref_way)))
    else $error("victim equals the way referenced in the previous cycle");

  // with an empty way present, a nonzero victim implies way 0 is valid
  assert_lowest_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&way_valid) && (victim_way != 2'd0)) |-> way_valid[0])
    else $error("lower empty way skipped");
endmodule

// File: tb/test_plru_repl_ctrl.sv
module test_plru_repl_ctrl;
  import plru_pkg::*;

  localparam int NUM_SETS = 64;
  localparam int SET_W    = $clog2(NUM_SETS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             acc_valid = 1'b0;
  logic [SET_W-1:0] acc_set = '0;
  logic             acc_hit = 1'b0;
  logic [1:0]       hit_way = '0;
  logic [3:0]       way_valid = 4'hF;
  logic [1:0]       fill_way = '0;
  logic [1:0]       victim_way;

  int total = 0;
  int bad   = 0;
  tree_t mdl [NUM_SETS];

  always #5 clk = ~clk;

  plru_repl_ctrl #(.NUM_SETS(NUM_SETS)) i_plru_repl_ctrl (
    .clk, .rst_n, .acc_valid, .acc_set, .acc_hit,
    .hit_way, .way_valid, .fill_way, .victim_way
  );

  function automatic logic [1:0] exp_victim(tree_t t, logic [3:0] v);
    for (int i = 0; i < 4; i++) if (!v[i]) return 2'(i);
    if (t.root == 1'b0) return t.lo_leaf ? 2'd1 : 2'd0;
    return t.hi_leaf ? 2'd3 : 2'd2;
  endfunction

  function automatic tree_t exp_next(tree_t t, logic [1:0] w);
    tree_t n = t;
    case (w)
      2'd0: begin n.root = 1; n.lo_leaf = 1; end
      2'd1: begin n.root = 1; n.lo_leaf = 0; end
      2'd2: begin n.root = 0; n.hi_leaf = 1; end
      default: begin n.root = 0; n.hi_leaf = 0; end
    endcase
    return n;
  endfunction

  // combinational read, called in the low phase with acc_valid low
  task automatic peek(input int s, input logic [3:0] v, input string req);
    logic [1:0] e;
    acc_set = SET_W'(s); way_valid = v;
    #1;
    e = exp_victim(mdl[s], v);
    total++;
    if (victim_way !== e) begin
      bad++;
      $display("FAIL %s set=%0d valid=%b got=%0d exp=%0d", req, s, v, victim_way, e);
    end
  endtask

  task automatic access(input int s, input logic hit, input logic [1:0] hw, input logic [1:0] fw);
    @(negedge clk);
    acc_valid = 1; acc_set = SET_W'(s); acc_hit = hit; hit_way = hw; fill_way = fw;
    @(negedge clk);
    acc_valid = 0;
    mdl[s] = exp_next(mdl[s], hit ? hw : fw);
  endtask

  task automatic t_reset;
    for (int s = 0; s < NUM_SETS; s += 9) peek(s, 4'hF, "R1");
    peek(NUM_SETS - 1, 4'hF, "R1");
  endtask

  // walks every victim table row; leaf retention shows after the root swings back
  task automatic t_tree_walk;
    access(3, 1, 2'd0, 2'd3); peek(3, 4'hF, "R3");  // way 2
    access(3, 1, 2'd2, 2'd0); peek(3, 4'hF, "R4");  // lo leaf kept 1 -> way 1
    access(3, 1, 2'd1, 2'd0); peek(3, 4'hF, "R3");  // hi leaf kept 1 -> way 3
    access(3, 1, 2'd3, 2'd0); peek(3, 4'hF, "R2");  // way 0
    access(3, 1, 2'd0, 2'd0); peek(3, 4'hF, "R2");  // way 2
  endtask

  task automatic t_empty_first;
    access(10, 1, 2'd1, 2'd0);  // tree points at pair 2/3
    peek(10, 4'b1110, "R5");
    peek(10, 4'b1101, "R5");
    peek(10, 4'b0011, "R5");
    peek(10, 4'b0111, "R5");
    peek(10, 4'b0000, "R5");
    peek(10, 4'b1010, "R5");
    peek(10, 4'hF, "R9");
  endtask

  task automatic t_hit_vs_fill;
    access(20, 1, 2'd2, 2'd0); peek(20, 4'hF, "R6");  // hit way 2 -> victim 0
    access(20, 0, 2'd0, 2'd1); peek(20, 4'hF, "R6");  // fill way 1 -> victim 3
  endtask

  task automatic t_idle;
    @(negedge clk);
    acc_valid = 0; acc_set = 6'd20; acc_hit = 1; hit_way = 2'd3; fill_way = 2'd3;
    repeat (3) @(negedge clk);
    peek(20, 4'hF, "R7");
  endtask

  task automatic t_isolation;
    access(30, 1, 2'd1, 2'd0);
    access(31, 1, 2'd0, 2'd0);
    access(31, 1, 2'd3, 2'd0);
    peek(30, 4'hF, "R8");
    peek(29, 4'hF, "R8");
    access(NUM_SETS - 1, 0, 2'd0, 2'd2);
    peek(NUM_SETS - 1, 4'hF, "R8");
    peek(0, 4'hF, "R8");
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    acc_valid = 1; acc_set = 6'd40; acc_hit = 1; hit_way = 2'd0;
    @(negedge clk);
    hit_way = 2'd2;
    @(negedge clk);
    acc_valid = 0;
    mdl[40] = exp_next(exp_next(mdl[40], 2'd0), 2'd2);
    peek(40, 4'hF, "R7");  // lo leaf from first access -> way 1
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < NUM_SETS; s++) mdl[s] = TREE_RESET;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tree_walk();
    t_empty_first();
    t_hit_vs_fill();
    t_idle();
    t_isolation();
    t_back_to_back();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule